// File: doc/BRIEF.md
# Stop-Mode Recovery Delay Sequencer

This block holds a small microcontroller's core in a stopped or waiting state and decides when it may run again. After power-on, after a low-voltage reset, and after each wake-up from stop mode, it counts a stabilization delay on the oscillator clock. Only when that count ends does it raise the run enable. While the core is stopped, it may also switch the oscillator off.

The length of the delay after a wake-up comes from a short-recovery configuration bit. A low-voltage reset always forces the long delay, and so does power-on. The core's stop request is honoured only when the stop-enable configuration bit is set. Otherwise the request is rejected with a one-cycle illegal-opcode pulse and the core keeps running. The block also holds a voltage-mode selection bit that only power-on clears.

All pins are plain control and status signals. No data stream passes through the block.

Top module: `stop_wake_seq`

## Requirements
- R1: While `por` is high, `run_en` and `illegal_op` are 0, `osc_en` is 1 and `vsel` is 0. `run_en` rises after exactly LONG_DLY (4096) rising clock edges following the release of `por`.
- R2: In the run state, a `stop_req` sampled with `cfg_stop_en`=1 (and `lvr`=0) drops `run_en` from the next cycle, and the block enters stop.
- R3: With `cfg_short_rec`=1, a `wake` sampled in stop at edge k raises `run_en` at edge k+SHORT_DLY (32).
- R4: With `cfg_short_rec`=0, a `wake` sampled in stop at edge k raises `run_en` at edge k+LONG_DLY (4096).
- R5: An `lvr` sampled at edge k, in any state, drops `run_en` from the next cycle. `run_en` then rises at edge k+LONG_DLY, whatever `cfg_short_rec` holds. This applies in stop and during a running recovery.
- R6: In the run state, a `stop_req` sampled with `cfg_stop_en`=0 gives `illegal_op`=1 for exactly the next cycle, and `run_en` stays 1.
- R7: In stop, `osc_en` is 0 when `clk_src[1]`=0 (code 0 is the on-chip oscillator, code 1 is a crystal) and `cfg_osc_in_stop`=0. It is 1 in every other case. It is 1 again from the cycle after the wake is sampled.
- R8: `vsel` takes `vsel_d` on a clock edge where `vsel_wr`=1 and otherwise holds. Only `por` clears it; `lvr` leaves it unchanged.
- R9: `wake` has no effect while running. `stop_req` has no effect during a recovery count, so the count still ends on time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-derived clock |
| por | input | 1 | Power-on reset, asynchronous, active high |
| lvr | input | 1 | Low-voltage reset event, synchronous, active high |
| wake | input | 1 | Wake-up event from stop |
| stop_req | input | 1 | Stop request from the CPU |
| cfg_stop_en | input | 1 | 1 = stop requests are allowed |
| cfg_short_rec | input | 1 | 1 = short wake-up delay |
| cfg_osc_in_stop | input | 1 | 1 = keep the oscillator running in stop |
| clk_src | input | 2 | Clock source: 0 on-chip oscillator, 1 crystal, 2/3 external clock |
| vsel_wr | input | 1 | Write strobe for the voltage-mode bit |
| vsel_d | input | 1 | Value to write into the voltage-mode bit |
| run_en | output | 1 | Core run enable |
| osc_en | output | 1 | Oscillator enable |
| illegal_op | output | 1 | One-cycle pulse when a stop request is rejected |
| vsel | output | 1 | Voltage-mode bit |

## Verification
The assertions take for granted that `clk` keeps toggling during stop, so that `wake` and `lvr` are seen as synchronous one-cycle events. They also take for granted that the configuration inputs do not change while a request is being sampled. The stimulus therefore drives every input at the falling edge. It pulses `stop_req`, `wake` and `lvr` for a single cycle, and it changes the configuration only while the core is running. The random choices cover clock source, short or long recovery, stop-enable, idle length in stop and voltage-mode writes.

// File: rtl/srd_pkg.sv
package srd_pkg;
  typedef enum logic [1:0] {
    ST_RSTWAIT = 2'd0,
    ST_RUN     = 2'd1,
    ST_HALT    = 2'd2,
    ST_WARM    = 2'd3
  } seq_state_t;
endpackage

// File: rtl/srd_delay_cnt.sv
module srd_delay_cnt #(
  parameter int LONG_DLY  = 4096,
  parameter int SHORT_DLY = 32,
  localparam int CW = $clog2(LONG_DLY)
) (
  input  logic clk,
  input  logic por,
  input  logic load,
  input  logic sel_short,
  output logic done
);
  localparam logic [CW-1:0] LONG_LD  = CW'(LONG_DLY - 1);
  localparam logic [CW-1:0] SHORT_LD = CW'(SHORT_DLY - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or posedge por) begin
    if (por)            cnt_q <= LONG_LD;
    else if (load)      cnt_q <= sel_short ? SHORT_LD : LONG_LD;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/srd_fsm.sv
module srd_fsm
  import srd_pkg::*;
(
  input  logic       clk,
  input  logic       por,
  input  logic       lvr,
  input  logic       wake,
  input  logic       stop_req,
  input  logic       stop_en,
  input  logic       short_cfg,
  input  logic       done,
  output seq_state_t state,
  output logic       load,
  output logic       ld_short,
  output logic       illegal_q
);
  seq_state_t nxt;
  logic       ill_d;

  always_comb begin
    nxt      = state;
    load     = 1'b0;
    ld_short = 1'b0;
    if (lvr) begin
      nxt  = ST_RSTWAIT;
      load = 1'b1;
    end else begin
      unique case (state)
        ST_RSTWAIT: if (done) nxt = ST_RUN;
        ST_RUN:     if (stop_req && stop_en) nxt = ST_HALT;
        ST_HALT: if (wake) begin
          nxt      = ST_WARM;
          load     = 1'b1;
          ld_short = short_cfg;
        end
        ST_WARM:    if (done) nxt = ST_RUN;
        default:    nxt = ST_RSTWAIT;
      endcase
    end
  end

  assign ill_d = !lvr && (state == ST_RUN) && stop_req && !stop_en;

  always_ff @(posedge clk or posedge por) begin
    if (por) begin
      state     <= ST_RSTWAIT;
      illegal_q <= 1'b0;
    end else begin
      state     <= nxt;
      illegal_q <= ill_d;
    end
  end
endmodule

// File: rtl/srd_vsel_reg.sv
module srd_vsel_reg (
  input  logic clk,
  input  logic por,
  input  logic wr,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk or posedge por) begin
    if (por)     q <= 1'b0;
    else if (wr) q <= d;
  end
endmodule

// File: rtl/stop_wake_seq.sv
module stop_wake_seq
  import srd_pkg::*;
#(
  parameter int LONG_DLY  = 4096,
  parameter int SHORT_DLY = 32
) (
  input  logic       clk,
  input  logic       por,
  input  logic       lvr,
  input  logic       wake,
  input  logic       stop_req,
  input  logic       cfg_stop_en,
  input  logic       cfg_short_rec,
  input  logic       cfg_osc_in_stop,
  input  logic [1:0] clk_src,
  input  logic       vsel_wr,
  input  logic       vsel_d,
  output logic       run_en,
  output logic       osc_en,
  output logic       illegal_op,
  output logic       vsel
);
  seq_state_t state;
  logic       load, ld_short, done;
  logic       osc_gateable;

  srd_fsm u_fsm (
    .clk       (clk),
    .por       (por),
    .lvr       (lvr),
    .wake      (wake),
    .stop_req  (stop_req),
    .stop_en   (cfg_stop_en),
    .short_cfg (cfg_short_rec),
    .done      (done),
    .state     (state),
    .load      (load),
    .ld_short  (ld_short),
    .illegal_q (illegal_op)
  );

  srd_delay_cnt #(
    .LONG_DLY  (LONG_DLY),
    .SHORT_DLY (SHORT_DLY)
  ) u_cnt (
    .clk       (clk),
    .por       (por),
    .load      (load),
    .sel_short (ld_short),
    .done      (done)
  );

  srd_vsel_reg u_vsel (
    .clk (clk),
    .por (por),
    .wr  (vsel_wr),
    .d   (vsel_d),
    .q   (vsel)
  );

  assign osc_gateable = !clk_src[1] && !cfg_osc_in_stop;
  assign run_en       = (state == ST_RUN);
  assign osc_en       = !((state == ST_HALT) && osc_gateable);
endmodule

// File: rtl/stop_wake_seq_chk.sv
module stop_wake_seq_chk (
  input logic       clk,
  input logic       por,
  input logic       lvr,
  input logic       stop_req,
  input logic       cfg_stop_en,
  input logic       cfg_osc_in_stop,
  input logic [1:0] clk_src,
  input logic       vsel_wr,
  input logic       run_en,
  input logic       osc_en,
  input logic       illegal_op,
  input logic       vsel
);
  // R2
  stop_drop_chk: assert property (@(posedge clk) disable iff (por)
    (run_en && stop_req && cfg_stop_en && !lvr) |=> !run_en);

  // R5
  lvr_drop_chk: assert property (@(posedge clk) disable iff (por)
    lvr |=> !run_en);

  // R6
  ill_cause_chk: assert property (@(posedge clk) disable iff (por)
    illegal_op |-> $past(run_en && stop_req && !cfg_stop_en));

  // R6
  ill_stay_chk: assert property (@(posedge clk) disable iff (por)
    (run_en && stop_req && !cfg_stop_en && !lvr) |=> run_en);

  // R7
  osc_gate_chk: assert property (@(posedge clk) disable iff (por)
    !osc_en |-> (!run_en && !clk_src[1] && !cfg_osc_in_stop));

  // R8
  vsel_hold_chk: assert property (@(posedge clk) disable iff (por)
    !vsel_wr |=> $stable(vsel));

  // R9
  run_keep_chk: assert property (@(posedge clk) disable iff (por)
    (run_en && !stop_req && !lvr) |=> run_en);
endmodule

bind stop_wake_seq stop_wake_seq_chk u_chk (
  .clk             (clk),
  .por             (por),
  .lvr             (lvr),
  .stop_req        (stop_req),
  .cfg_stop_en     (cfg_stop_en),
  .cfg_osc_in_stop (cfg_osc_in_stop),
  .clk_src         (clk_src),
  .vsel_wr         (vsel_wr),
  .run_en          (run_en),
  .osc_en          (osc_en),
  .illegal_op      (illegal_op),
  .vsel            (vsel)
);

// File: tb/stop_wake_seq_tb.sv
module stop_wake_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LONG_DLY   = 4096;
  localparam int SHORT_DLY  = 32;

  logic clk = 1'b0;
  logic por, lvr, wake, stop_req, cfg_stop_en, cfg_short_rec, cfg_osc_in_stop;
  logic [1:0] clk_src;
  logic vsel_wr, vsel_d;
  logic run_en, osc_en, illegal_op, vsel;
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  bit vsel_exp = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stop_wake_seq #(.LONG_DLY(LONG_DLY), .SHORT_DLY(SHORT_DLY)) u_dut (
    .clk(clk), .por(por), .lvr(lvr), .wake(wake), .stop_req(stop_req),
    .cfg_stop_en(cfg_stop_en), .cfg_short_rec(cfg_short_rec),
    .cfg_osc_in_stop(cfg_osc_in_stop), .clk_src(clk_src),
    .vsel_wr(vsel_wr), .vsel_d(vsel_d), .run_en(run_en), .osc_en(osc_en),
    .illegal_op(illegal_op), .vsel(vsel)
  );

  function automatic int exp_dly(bit sh, bit by_lvr);
    if (by_lvr) return LONG_DLY;
    return sh ? SHORT_DLY : LONG_DLY;
  endfunction

  function automatic logic exp_osc_stop(logic [1:0] src, logic ois);
    return src[1] | ois;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_run(int n, string req);
    repeat (n - 1) cyc();
    chk(req, run_en, 1'b0);
    cyc();
    chk(req, run_en, 1'b1);
  endtask

  task automatic enter_stop(bit sh, logic [1:0] src, bit ois, int idle);
    cfg_stop_en = 1; cfg_short_rec = sh; clk_src = src; cfg_osc_in_stop = ois;
    stop_req = 1; cyc(); stop_req = 0;
    chk("R2 stop", run_en, 1'b0);
    chk("R7 osc in stop", osc_en, exp_osc_stop(src, ois));
    for (int i = 0; i < idle; i++) begin
      cyc();
      chk("R7 osc in stop", osc_en, exp_osc_stop(src, ois));
    end
  endtask

  task automatic do_wake(bit sh);
    wake = 1; cyc(); wake = 0;
    chk("R7 osc after wake", osc_en, 1'b1);
    wait_run(exp_dly(sh, 0), sh ? "R3 short" : "R4 long");
  endtask

  task automatic do_lvr();
    lvr = 1; cyc(); lvr = 0;
    chk("R5 lvr drop", run_en, 1'b0);
    chk("R8 vsel after lvr", vsel, vsel_exp);
    wait_run(exp_dly(cfg_short_rec, 1), "R5 lvr delay");
  endtask

  task automatic do_illegal();
    cfg_stop_en = 0; stop_req = 1; cyc(); stop_req = 0;
    chk("R6 pulse", illegal_op, 1'b1);
    chk("R6 run", run_en, 1'b1);
    cyc();
    chk("R6 one cycle", illegal_op, 1'b0);
    chk("R6 run", run_en, 1'b1);
    cfg_stop_en = 1;
  endtask

  task automatic do_vsel(bit v);
    vsel_wr = 1; vsel_d = v; cyc(); vsel_wr = 0; vsel_exp = v;
    chk("R8 write", vsel, vsel_exp);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    por = 1; lvr = 0; wake = 0; stop_req = 0; cfg_stop_en = 1;
    cfg_short_rec = 1; cfg_osc_in_stop = 0; clk_src = 2'd0;
    vsel_wr = 0; vsel_d = 0;
    repeat (3) cyc();
    // R1 reset state
    chk("R1 run", run_en, 1'b0);
    chk("R1 osc", osc_en, 1'b1);
    chk("R1 ill", illegal_op, 1'b0);
    chk("R1 vsel", vsel, 1'b0);
    por = 0;
    wait_run(LONG_DLY, "R1 por delay");

    // Directed corners
    enter_stop(1, 2'd0, 0, 3); do_wake(1);
    enter_stop(0, 2'd1, 0, 2); do_wake(0);
    enter_stop(1, 2'd2, 0, 2); do_wake(1);
    enter_stop(1, 2'd1, 1, 1); do_wake(1);
    do_illegal();
    // R9 wake while running is ignored
    wake = 1; cyc(); wake = 0;
    chk("R9 wake in run", run_en, 1'b1);
    chk("R9 wake in run osc", osc_en, 1'b1);
    // R9 stop request during recovery is ignored
    enter_stop(1, 2'd0, 0, 1);
    wake = 1; cyc(); wake = 0;
    stop_req = 1; cyc(); stop_req = 0;
    wait_run(SHORT_DLY - 1, "R9 stop in recovery");
    // R5 lvr in stop with short bit set
    do_vsel(1);
    enter_stop(1, 2'd0, 0, 2); do_lvr();
    // R5 lvr during short recovery
    enter_stop(1, 2'd1, 0, 1);
    wake = 1; cyc(); wake = 0;
    repeat (5) cyc();
    do_lvr();

    // Random mix
    for (int it = 0; it < 40; it++) begin
      int op;
      op = int'($urandom % 8);
      if (op <= 2) begin
        do_illegal();
      end else if (op <= 5) begin
        bit sh;
        sh = ($urandom % 4) != 0;
        enter_stop(sh, 2'($urandom % 4), 1'($urandom % 2), int'($urandom % 6));
        do_wake(sh);
      end else if (op == 6) begin
        enter_stop(1'($urandom % 2), 2'($urandom % 4), 1'($urandom % 2), int'($urandom % 4));
        do_lvr();
      end else begin
        do_vsel(1'($urandom % 2));
      end
    end

    // R8 only power-on clears vsel
    do_vsel(1);
    por = 1; cyc();
    chk("R8 por clears", vsel, 1'b0);
    chk("R1 run in por", run_en, 1'b0);
    vsel_exp = 0;
    por = 0;
    wait_run(LONG_DLY, "R1 por delay again");

    finished = 1;
    summary();
    $finish;
  end
endmodule